// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on a single line output. It uses a 16x oversampling tick from outside, so every bit cell is a whole number of ticks. A byte sits in a one-entry holding register. When the line is free and the transmitter is enabled, the byte moves into a shifter. It is sent as a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop period that is high. The stop period lasts one, one and a half, or two bit cells.

A two-bit transmit control field sets three things: whether the transmitter runs, the level of the request-to-send output, and whether a continuous break is held on the line. It also gates a transmit-service request that follows the holding-register empty flag. In echo mode the holding register is filled from a received byte strobe and not from the host, and those bytes are sent even while the transmit control field is off. Frame settings are captured when a byte enters the shifter, so a setting change never alters a frame that is already on the line.

Top module: `tx_async_serializer`

## Requirements
- R1: After reset, `txd` is high, `hold_empty` is 1, `rts_n` is 1 and `tx_int_req` is 0.
- R2: A frame is a low start bit, then N data bits with the LSB first, each cell 16 ticks long. `cfg_wlen` selects N: 00=8, 01=7, 10=6, 11=5.
- R3: With `cfg_par_en`=1 a parity bit follows the data. `cfg_par_mode` selects it: 00 makes the count of ones in data plus parity odd, 01 makes it even, 10 always sends 1, 11 always sends 0. With `cfg_par_en`=0 no parity bit is sent.
- R4: The stop period is high for 16 ticks when `cfg_stop_long`=0. When `cfg_stop_long`=1 it is 32 ticks, except 16 ticks for 8 data bits with parity and 24 ticks for 5 data bits without parity.
- R5: With `cfg_txctl`=00 (and echo off) no frame starts, the holding register stays full, `txd` stays high and `rts_n` is 1.
- R6: With `cfg_txctl`=01 or 10, `rts_n` is 0 and frames are sent. `tx_int_req` equals `hold_empty` under 01 and is 0 under every other code.
- R7: With `cfg_txctl`=11, `rts_n` is 0. Once any frame in progress has finished, `txd` is held low for as long as the code stays 11. After the break ends, `txd` is high for exactly 16 ticks before the next frame can start.
- R8: `hold_empty` goes to 0 on the clock edge after a write. It goes to 1 on the same edge on which the byte enters the shifter and the start bit begins.
- R9: If the holding register is full when a stop period ends, the next start bit begins at once, with no idle gap.
- R10: With `echo_en`=1, `echo_stb` loads `echo_byte` into the holding register, host writes are ignored, and the echoed byte is sent even when `cfg_txctl`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16x oversampling enable |
| cfg_wlen | input | 2 | Data bit count code |
| cfg_stop_long | input | 1 | Long stop period select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_mode | input | 2 | Parity type |
| cfg_txctl | input | 2 | Transmit control: off, on with service request, on, break |
| echo_en | input | 1 | Echo mode enable |
| host_wr | input | 1 | Host write strobe for the holding register |
| host_byte | input | 8 | Host byte |
| echo_stb | input | 1 | Received byte strobe for echo |
| echo_byte | input | 8 | Received byte to echo |
| txd | output | 1 | Serial line, idles high |
| rts_n | output | 1 | Request to send, active low |
| hold_empty | output | 1 | Holding register empty |
| tx_int_req | output | 1 | Transmit service request |

## Verification
The line changes on the same clock edge on which the state register changes. The start bit therefore appears one edge after a write to an idle, enabled transmitter, and each later cell begins exactly 16 ticks after the one before it. `hold_empty` falls one edge after a write and rises on the edge on which the start bit begins. `rts_n` and `tx_int_req` follow the control field within the same cycle. The bench samples on falling clock edges and counts falling edges from the first low sample of each start bit. It reads each cell at its midpoint, tick 8, and checks every stop sample against the tick count from R4. For back-to-back frames and for the end of a break it also checks the exact sample on which the line must go low again.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK,
        ST_MARK
    } tx_state_e;

    typedef enum logic [1:0] {
        TXC_OFF     = 2'b00,
        TXC_ON_IRQ  = 2'b01,
        TXC_ON      = 2'b10,
        TXC_BREAK   = 2'b11
    } txc_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       stop_long;
        logic       par_en;
        logic [1:0] par_mode;
    } tx_cfg_t;

    function automatic logic [3:0] word_bits(input logic [1:0] wlen);
        return 4'd8 - {2'b00, wlen};
    endfunction

    function automatic logic par_value(input logic [1:0] mode,
                                       input logic [DATA_W-1:0] d,
                                       input logic [3:0] n);
        logic x;
        x = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(n)) x = x ^ d[i];
        end
        case (mode)
            2'b00:   return ~x;
            2'b01:   return x;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int stop_len(input tx_cfg_t c, input int ovs);
        if (!c.stop_long)                       return ovs;
        else if (c.wlen == 2'b00 && c.par_en)   return ovs;
        else if (c.wlen == 2'b11 && !c.par_en)  return ovs + ovs / 2;
        else                                    return 2 * ovs;
    endfunction

endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg
    import tx_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr) begin
            full <= 1'b1;
            data <= wdata;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R8: a write leaves the register full on the next edge
    a_r8_wr_fills: assert property (@(posedge clk) disable iff (rst)
        wr |=> full);

    // R8: the shifter only takes a byte that is present
    a_r8_take_needs_full: assert property (@(posedge clk) disable iff (rst)
        take |-> full);

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
    import tx_ser_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  logic              brk_req,
    input  tx_cfg_t           cfg,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_byte,
    output logic              take,
    output logic              line_bit,
    output logic              brk_on,
    output logic              in_stop
);

    localparam int CW = $clog2(2 * OVS + 1);
    localparam int BW = $clog2(DATA_W);

    typedef struct packed {
        logic [3:0]    nbits;
        logic          par_en;
        logic          par_bit;
        logic [CW-1:0] stop;
    } frame_t;

    tx_state_e         st;
    logic [CW-1:0]     tcnt;
    logic [DATA_W-1:0] shreg;
    logic [BW-1:0]     bidx;
    frame_t            fr;

    logic bit_end, stop_end, ready;

    always_comb begin
        bit_end  = tick && (tcnt == CW'(OVS - 1));
        stop_end = tick && (tcnt == fr.stop - CW'(1));
        ready    = hold_full && run && !brk_req;
        take     = ready && ((st == ST_IDLE) ||
                             (st == ST_STOP && stop_end) ||
                             (st == ST_MARK && bit_end));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            tcnt  <= '0;
            shreg <= '0;
            bidx  <= '0;
            fr    <= '0;
        end else if (take) begin
            st        <= ST_START;
            tcnt      <= '0;
            shreg     <= hold_byte;
            fr.nbits  <= word_bits(cfg.wlen);
            fr.par_en <= cfg.par_en;
            fr.par_bit <= par_value(cfg.par_mode, hold_byte, word_bits(cfg.wlen));
            fr.stop   <= CW'(stop_len(cfg, OVS));
        end else begin
            case (st)
                ST_IDLE: begin
                    if (brk_req) st <= ST_BRK;
                    tcnt <= '0;
                end
                ST_START: begin
                    if (bit_end) begin
                        st   <= ST_DATA;
                        tcnt <= '0;
                        bidx <= '0;
                    end else if (tick) begin
                        tcnt <= tcnt + CW'(1);
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        tcnt  <= '0;
                        shreg <= shreg >> 1;
                        if (bidx == BW'(fr.nbits - 4'd1))
                            st <= fr.par_en ? ST_PAR : ST_STOP;
                        else
                            bidx <= bidx + BW'(1);
                    end else if (tick) begin
                        tcnt <= tcnt + CW'(1);
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        st   <= ST_STOP;
                        tcnt <= '0;
                    end else if (tick) begin
                        tcnt <= tcnt + CW'(1);
                    end
                end
                ST_STOP: begin
                    if (stop_end) begin
                        st   <= ST_IDLE;
                        tcnt <= '0;
                    end else if (tick) begin
                        tcnt <= tcnt + CW'(1);
                    end
                end
                ST_BRK: begin
                    tcnt <= '0;
                    if (!brk_req) st <= ST_MARK;
                end
                ST_MARK: begin
                    if (bit_end) begin
                        st   <= ST_IDLE;
                        tcnt <= '0;
                    end else if (tick) begin
                        tcnt <= tcnt + CW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st)
            ST_START: line_bit = 1'b0;
            ST_DATA:  line_bit = shreg[0];
            ST_PAR:   line_bit = fr.par_bit;
            default:  line_bit = 1'b1;
        endcase
        brk_on  = (st == ST_BRK);
        in_stop = (st == ST_STOP);
    end

    // R5: an idle transmitter that is not enabled never begins a frame
    a_r5_off_no_start: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !run) |=> (st != ST_START));

    // R7: a break is only entered from the idle state
    a_r7_break_from_idle: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BRK && $past(st) != ST_BRK) |-> $past(st) == ST_IDLE);

endmodule

// File: rtl/tx_line_ctl.sv
module tx_line_ctl
    import tx_ser_pkg::*;
(
    input  logic [1:0] txctl,
    input  logic       echo_en,
    input  logic       line_bit,
    input  logic       brk_on,
    input  logic       hold_empty,
    output logic       txd,
    output logic       rts_n,
    output logic       run,
    output logic       brk_req,
    output logic       tx_int_req
);

    txc_e mode;

    always_comb begin
        mode       = txc_e'(txctl);
        run        = (mode == TXC_ON_IRQ) || (mode == TXC_ON) || echo_en;
        brk_req    = (mode == TXC_BREAK) && !echo_en;
        rts_n      = (mode == TXC_OFF);
        tx_int_req = hold_empty && (mode == TXC_ON_IRQ);
        txd        = brk_on ? 1'b0 : line_bit;
    end

endmodule

// File: rtl/tx_async_serializer.sv
module tx_async_serializer
    import tx_ser_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_stop_long,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    input  logic [1:0] cfg_txctl,
    input  logic       echo_en,
    input  logic       host_wr,
    input  logic [7:0] host_byte,
    input  logic       echo_stb,
    input  logic [7:0] echo_byte,
    output logic       txd,
    output logic       rts_n,
    output logic       hold_empty,
    output logic       tx_int_req
);

    tx_cfg_t           cfg;
    logic              load;
    logic [DATA_W-1:0] load_byte;
    logic              take, hold_full;
    logic [DATA_W-1:0] hold_byte;
    logic              line_bit, brk_on, in_stop, run, brk_req;

    always_comb begin
        cfg.wlen      = cfg_wlen;
        cfg.stop_long = cfg_stop_long;
        cfg.par_en    = cfg_par_en;
        cfg.par_mode  = cfg_par_mode;
        load          = echo_en ? echo_stb : host_wr;
        load_byte     = echo_en ? echo_byte : host_byte;
        hold_empty    = !hold_full;
    end

    tx_hold_reg u_hold (
        .clk   (clk),
        .rst   (rst),
        .wr    (load),
        .wdata (load_byte),
        .take  (take),
        .full  (hold_full),
        .data  (hold_byte)
    );

    tx_frame_seq #(.OVS(OVS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .run       (run),
        .brk_req   (brk_req),
        .cfg       (cfg),
        .hold_full (hold_full),
        .hold_byte (hold_byte),
        .take      (take),
        .line_bit  (line_bit),
        .brk_on    (brk_on),
        .in_stop   (in_stop)
    );

    tx_line_ctl u_line (
        .txctl      (cfg_txctl),
        .echo_en    (echo_en),
        .line_bit   (line_bit),
        .brk_on     (brk_on),
        .hold_empty (hold_empty),
        .txd        (txd),
        .rts_n      (rts_n),
        .run        (run),
        .brk_req    (brk_req),
        .tx_int_req (tx_int_req)
    );

    // R1: the first cycle after reset shows an idle line and an empty register
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (txd && hold_empty));

    // R2: taking a byte starts the low start bit on the next cycle
    a_r2_take_start_low: assert property (@(posedge clk) disable iff (rst)
        take |=> !txd);

    // R4: the stop period is always a high level
    a_r4_stop_high: assert property (@(posedge clk) disable iff (rst)
        in_stop |-> txd);

    // R7: while the break state is held, the line is low
    a_r7_break_low: assert property (@(posedge clk) disable iff (rst)
        brk_on |-> !txd);

    // R8: taking a byte empties the register unless a write lands at once
    a_r8_take_empties: assert property (@(posedge clk) disable iff (rst)
        (take && !load) |=> hold_empty);

endmodule

// File: tb/tx_async_serializer_tb.sv
module tx_async_serializer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int OVS = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b1;
    logic [1:0] cfg_wlen = 2'b00;
    logic       cfg_stop_long = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'b00;
    logic [1:0] cfg_txctl = 2'b00;
    logic       echo_en = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic       echo_stb = 1'b0;
    logic [7:0] echo_byte = 8'h00;
    logic       txd, rts_n, hold_empty, tx_int_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_async_serializer #(.OVS(OVS)) u_dut (
        .clk(clk), .rst(rst), .tick16(tick16),
        .cfg_wlen(cfg_wlen), .cfg_stop_long(cfg_stop_long),
        .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
        .cfg_txctl(cfg_txctl), .echo_en(echo_en),
        .host_wr(host_wr), .host_byte(host_byte),
        .echo_stb(echo_stb), .echo_byte(echo_byte),
        .txd(txd), .rts_n(rts_n), .hold_empty(hold_empty),
        .tx_int_req(tx_int_req)
    );

    typedef struct {
        logic [7:0] data;
        int         nbits;
        bit         has_par;
        logic       pbit;
        int         stop;
        bit         b2b;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   mon_on = 1'b1;
    bit   mon_busy = 1'b0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic exp_t make_exp(input logic [7:0] d, input bit b2b);
        exp_t e;
        int   ones;
        e.nbits   = 8 - int'(cfg_wlen);
        e.data    = d & 8'((1 << e.nbits) - 1);
        e.has_par = cfg_par_en;
        ones = 0;
        for (int i = 0; i < e.nbits; i++) ones += int'(e.data[i]);
        case (cfg_par_mode)
            2'b00:   e.pbit = (ones % 2 == 0);
            2'b01:   e.pbit = (ones % 2 == 1);
            2'b10:   e.pbit = 1'b1;
            default: e.pbit = 1'b0;
        endcase
        if (!cfg_stop_long)                     e.stop = OVS;
        else if (e.nbits == 8 && cfg_par_en)    e.stop = OVS;
        else if (e.nbits == 5 && !cfg_par_en)   e.stop = OVS + OVS/2;
        else                                    e.stop = 2*OVS;
        e.b2b = b2b;
        return e;
    endfunction

    // driver: push expectation, then write the holding register
    task automatic send(input logic [7:0] d, input bit b2b);
        q.push_back(make_exp(d, b2b));
        host_byte = d;
        host_wr   = 1'b1;
        @(negedge clk);
        host_wr   = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (q.size() != 0 || mon_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: called on the first low sample of a start bit
    task automatic grab(output bit nxt);
        exp_t e;
        logic s[0:255];
        int   base, last;
        logic [7:0] got;
        nxt = 1'b0;
        if (q.size() == 0) begin
            chk(1'b0, "R5 unexpected frame", 1, 0);
            return;
        end
        e = q.pop_front();
        base = OVS * (1 + e.nbits + int'(e.has_par));
        last = base + e.stop - 1 + (e.b2b ? 1 : 0);
        s[0] = txd;
        for (int i = 1; i <= last; i++) begin
            @(negedge clk);
            s[i] = txd;
        end
        chk(s[OVS/2] == 1'b0, "R2 start bit", int'(s[OVS/2]), 0);
        got = 8'h00;
        for (int k = 0; k < e.nbits; k++) got[k] = s[OVS/2 + OVS*(k+1)];
        chk(got == e.data, "R2 data bits", int'(got), int'(e.data));
        if (e.has_par)
            chk(s[OVS/2 + OVS*(1+e.nbits)] == e.pbit, "R3 parity bit",
                int'(s[OVS/2 + OVS*(1+e.nbits)]), int'(e.pbit));
        begin
            int hi;
            hi = 0;
            for (int i = base; i < base + e.stop; i++) hi += int'(s[i] == 1'b1);
            chk(hi == e.stop, "R4 stop period high ticks", hi, e.stop);
        end
        if (e.b2b) begin
            chk(s[last] == 1'b0, "R9 next start right after stop", int'(s[last]), 0);
            nxt = (s[last] == 1'b0);
        end
    endtask

    initial begin
        logic lastv;
        bit   nxt;
        lastv = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst && mon_on && lastv && !txd) begin
                mon_busy = 1'b1;
                do grab(nxt); while (nxt);
                mon_busy = 1'b0;
            end
            lastv = txd;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        chk(hold_empty == 1'b1, "R1 hold_empty", int'(hold_empty), 1);
        chk(rts_n == 1'b1, "R1 rts_n", int'(rts_n), 1);
        chk(tx_int_req == 1'b0, "R1 tx_int_req", int'(tx_int_req), 0);

        // R6 control codes 01 / 10
        cfg_txctl = 2'b01;
        @(negedge clk);
        chk(rts_n == 1'b0, "R6 rts_n low in 01", int'(rts_n), 0);
        chk(tx_int_req == 1'b1, "R6 service request in 01 when empty", int'(tx_int_req), 1);
        cfg_txctl = 2'b10;
        @(negedge clk);
        chk(tx_int_req == 1'b0, "R6 no service request in 10", int'(tx_int_req), 0);
        chk(rts_n == 1'b0, "R6 rts_n low in 10", int'(rts_n), 0);

        // R2 word lengths, R3 parity modes
        send(8'hA5, 1'b0); drain();
        cfg_wlen = 2'b01; cfg_par_en = 1'b1; cfg_par_mode = 2'b00;
        send(8'hB5, 1'b0); drain();
        cfg_wlen = 2'b10; cfg_par_mode = 2'b01;
        send(8'h2B, 1'b0); drain();
        cfg_wlen = 2'b11; cfg_par_mode = 2'b10;
        send(8'h14, 1'b0); drain();
        cfg_wlen = 2'b00; cfg_par_mode = 2'b11;
        send(8'hFF, 1'b0); drain();
        cfg_par_mode = 2'b00;
        send(8'h01, 1'b0); drain();

        // R4 stop lengths measured exactly with R9 back-to-back frames
        cfg_stop_long = 1'b1;
        cfg_wlen = 2'b00; cfg_par_en = 1'b0;                     // 32 ticks
        send(8'h3C, 1'b1);
        while (!hold_empty) @(negedge clk);
        send(8'hC3, 1'b0); drain();
        cfg_wlen = 2'b00; cfg_par_en = 1'b1; cfg_par_mode = 2'b01; // 16 ticks
        send(8'h5A, 1'b1);
        while (!hold_empty) @(negedge clk);
        send(8'h0F, 1'b0); drain();
        cfg_wlen = 2'b11; cfg_par_en = 1'b0;                     // 24 ticks
        send(8'h15, 1'b1);
        while (!hold_empty) @(negedge clk);
        send(8'h0A, 1'b0); drain();
        cfg_wlen = 2'b10; cfg_par_en = 1'b1; cfg_par_mode = 2'b00; // 32 ticks
        send(8'h21, 1'b1);
        while (!hold_empty) @(negedge clk);
        send(8'h12, 1'b0); drain();
        cfg_stop_long = 1'b0; cfg_wlen = 2'b00; cfg_par_en = 1'b0;

        // R8 and R5: write with transmitter off
        cfg_txctl = 2'b00;
        @(negedge clk);
        chk(rts_n == 1'b1, "R5 rts_n high in 00", int'(rts_n), 1);
        host_byte = 8'h6E; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        chk(hold_empty == 1'b0, "R8 empty clears after write", int'(hold_empty), 0);
        cnt = 0;
        repeat (40) begin
            @(negedge clk);
            cnt += int'(txd == 1'b1 && hold_empty == 1'b0);
        end
        chk(cnt == 40, "R5 no frame while off", cnt, 40);
        q.push_back(make_exp(8'h6E, 1'b0));
        cfg_txctl = 2'b10;
        @(negedge clk);
        chk(hold_empty == 1'b1 && txd == 1'b0, "R8 empty sets as start begins",
            int'({hold_empty, txd}), 2);
        drain();

        // R6: service request drops while full under 01
        cfg_txctl = 2'b01;
        send(8'h44, 1'b0);
        chk(tx_int_req == 1'b0, "R6 no request while register full", int'(tx_int_req), 0);
        drain();
        chk(tx_int_req == 1'b1, "R6 request after byte moved", int'(tx_int_req), 1);

        // R7 break from idle, then 16-tick mark before pending frame
        mon_on = 1'b0;
        cfg_txctl = 2'b11;
        @(negedge clk);
        chk(txd == 1'b0 && rts_n == 1'b0, "R7 break drives line low", int'({txd, rts_n}), 0);
        host_byte = 8'h99; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        cnt = 0;
        repeat (40) begin
            @(negedge clk);
            cnt += int'(txd == 1'b0);
        end
        chk(cnt == 40, "R7 break held", cnt, 40);
        q.push_back(make_exp(8'h99, 1'b0));
        cfg_txctl = 2'b10;
        mon_on = 1'b1;
        cnt = 0;
        @(negedge clk);
        while (txd == 1'b1 && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == OVS, "R7 mark length after break", cnt, OVS);
        drain();

        // R7 break requested mid-frame lets the frame finish
        send(8'h81, 1'b0);
        repeat (40) @(negedge clk);
        cfg_txctl = 2'b11;
        mon_on = 1'b0;
        drain();
        chk(txd == 1'b0, "R7 break after frame completes", int'(txd), 0);
        cfg_txctl = 2'b00;
        repeat (24) @(negedge clk);
        chk(txd == 1'b1, "R7 line high after break", int'(txd), 1);
        mon_on = 1'b1;

        // R10 echo mode
        echo_en = 1'b1;
        host_byte = 8'h77; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        chk(hold_empty == 1'b1, "R10 host write ignored in echo", int'(hold_empty), 1);
        cnt = 0;
        repeat (40) begin
            @(negedge clk);
            cnt += int'(txd == 1'b1);
        end
        chk(cnt == 40, "R10 no frame from host write", cnt, 40);
        q.push_back(make_exp(8'h5C, 1'b0));
        echo_byte = 8'h5C; echo_stb = 1'b1;
        @(negedge clk);
        echo_stb = 1'b0;
        drain();
        chk(q.size() == 0, "R10 echoed byte sent with control off", q.size(), 0);
        echo_en = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule